// File: doc/BRIEF.md
# Rectangular-Window Spike-Timing Efficacy Updater

This block is the learning unit attached to one synapse. It keeps a 4-bit synaptic efficacy in a saturating up/down counter. It moves that efficacy by exactly one step whenever a presynaptic and a postsynaptic spike fall close enough together in time.

Each spike strobe is one cycle wide. The block times each strobe with its own saturating tick counter. If a post spike follows a pre spike within the potentiation window, the efficacy goes up by one. If a pre spike follows a post spike within the depression window, the efficacy goes down by one. Pairs farther apart than the window have no effect. The timing difference never scales the step, so the learning function is rectangular.

Both window lengths are inputs, so outside logic can widen the depression window while the block runs. A load port sets the starting efficacy.

Top module: `stdp_rect_updater`

## Requirements
- R1: After reset the efficacy is 0 and both event flags are low. Both spike timers mean "no recent spike", so a first lone spike of either kind causes no update.
- R2: A post strobe that arrives d clock edges after a pre strobe, with 1 <= d <= `ltp_win_i`, increments the efficacy by one. `ltp_o` is high during the cycle after the edge that took the post strobe.
- R3: A pre strobe that arrives d clock edges after a post strobe, with 1 <= d <= `ltd_win_i`, decrements the efficacy by one. `ltd_o` is high during the cycle after the edge that took the pre strobe.
- R4: A pair with d greater than the relevant window length causes no change and no flag. A window length of 0 disables that kind of update entirely.
- R5: Pre and post strobes in the same cycle cause neither an increment nor a decrement.
- R6: The efficacy saturates. An increment at 15 leaves it at 15, and a decrement at 0 leaves it at 0. The matching event flag still pulses.
- R7: Pairing is nearest-neighbour. Once a spike has caused an update, it is used up. A later spike of the opposite kind, with no new earlier spike in between, causes no second update.
- R8: While `load_i` is high, the efficacy takes `load_val_i` at the next edge. A learning update in the same cycle is discarded and neither flag is raised.
- R9: A new `ltd_win_i` value applies to the very next comparison, without reset. The potentiation behaviour does not change.
- R10: Each event flag is a one-cycle pulse. The efficacy never changes by more than one code per cycle, except through the load port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre_i | input | 1 | Presynaptic spike strobe, one cycle wide |
| post_i | input | 1 | Postsynaptic spike strobe, one cycle wide |
| ltp_win_i | input | 16 | Potentiation window length in ticks (0 disables potentiation) |
| ltd_win_i | input | 16 | Depression window length in ticks (0 disables depression) |
| load_i | input | 1 | Load strobe for the efficacy |
| load_val_i | input | 4 | Efficacy value to load |
| eff_o | output | 4 | Current synaptic efficacy |
| ltp_o | output | 1 | One-cycle pulse: potentiation event applied |
| ltd_o | output | 1 | One-cycle pulse: depression event applied |

## Verification
Pre-then-post pairs are tried at gaps of one tick, exactly the window, and one tick past it. These three gaps show whether the inclusive window edge is placed correctly. The mirrored post-then-pre pairs test depression in the same way, and a zero-length window shows that the update is switched off.

Coincident strobes show whether same-cycle spikes are suppressed. A repeated second spike after an update shows whether the earlier spike was consumed, which separates nearest-neighbour pairing from all-pairs pairing.

Loads at 15 and at 0 followed by a qualifying pair show saturation. A load in the same cycle as a qualifying spike shows load priority. Widening the depression window between two pre spikes shows that the new length applies at once.

// File: rtl/stdp_pkg.sv
package stdp_pkg;
  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_INC  = 2'd1,
    UPD_DEC  = 2'd2
  } upd_e;
endpackage

// File: rtl/spike_timer.sv
module spike_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         clear_i,
  output logic [W-1:0] age_o
);
  localparam logic [W-1:0] SAT = '1;

  logic [W-1:0] age_q;

  // all-ones means no recent spike
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= SAT;
    else if (start_i)       age_q <= '0;
    else if (clear_i)       age_q <= SAT;
    else if (age_q != SAT)  age_q <= age_q + 1'b1;
  end

  assign age_o = age_q;

  // R2
  timer_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> age_q == '0);

  // R7
  timer_consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !start_i) |=> age_q == SAT);

  // R1
  timer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == SAT && !start_i) |=> age_q == SAT);
endmodule

// File: rtl/window_decider.sv
module window_decider
  import stdp_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          pre_i,
  input  logic          post_i,
  input  logic [TW-1:0] pre_age_i,
  input  logic [TW-1:0] post_age_i,
  input  logic [TW-1:0] ltp_win_i,
  input  logic [TW-1:0] ltd_win_i,
  output upd_e          upd_o,
  output logic          clr_pre_o,
  output logic          clr_post_o
);
  logic ltp_hit, ltd_hit;

  // age counts from 0 at the first edge after a spike, so elapsed = age + 1
  // elapsed <= win  <=>  age < win ; win == 0 never hits
  assign ltp_hit = post_i && !pre_i && (pre_age_i < ltp_win_i);
  assign ltd_hit = pre_i && !post_i && (post_age_i < ltd_win_i);

  always_comb begin
    upd_o = UPD_NONE;
    if (ltp_hit)      upd_o = UPD_INC;
    else if (ltd_hit) upd_o = UPD_DEC;
  end

  assign clr_pre_o  = ltp_hit;
  assign clr_post_o = ltd_hit;
endmodule

// File: rtl/eff_counter.sv
module eff_counter
  import stdp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  upd_e         upd_i,
  output logic [W-1:0] eff_o,
  output logic         inc_o,
  output logic         dec_o
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] MINV = '0;

  logic [W-1:0] eff_q;
  logic         inc_q, dec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q <= MINV;
      inc_q <= 1'b0;
      dec_q <= 1'b0;
    end else if (load_i) begin
      eff_q <= load_val_i;
      inc_q <= 1'b0;
      dec_q <= 1'b0;
    end else begin
      inc_q <= (upd_i == UPD_INC);
      dec_q <= (upd_i == UPD_DEC);
      if (upd_i == UPD_INC && eff_q != MAXV)      eff_q <= eff_q + 1'b1;
      else if (upd_i == UPD_DEC && eff_q != MINV) eff_q <= eff_q - 1'b1;
    end
  end

  assign eff_o = eff_q;
  assign inc_o = inc_q;
  assign dec_o = dec_q;

  // R8
  load_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (eff_q == $past(load_val_i)) && !inc_q && !dec_q);

  // R10
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (eff_q == $past(eff_q)) ||
                (eff_q == W'($past(eff_q) + 1'b1)) ||
                (eff_q == W'($past(eff_q) - 1'b1)));

  // R6
  sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_q == MAXV && !load_i) |=> eff_q >= MAXV - 1'b1);

  // R6
  sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_q == MINV && !load_i) |=> eff_q <= MINV + 1'b1);
endmodule

// File: rtl/stdp_rect_updater.sv
module stdp_rect_updater
  import stdp_pkg::*;
#(
  parameter int EFF_W = 4,
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_i,
  input  logic             post_i,
  input  logic [TMR_W-1:0] ltp_win_i,
  input  logic [TMR_W-1:0] ltd_win_i,
  input  logic             load_i,
  input  logic [EFF_W-1:0] load_val_i,
  output logic [EFF_W-1:0] eff_o,
  output logic             ltp_o,
  output logic             ltd_o
);
  logic [TMR_W-1:0] pre_age, post_age;
  logic             clr_pre, clr_post;
  upd_e             upd;

  spike_timer #(.W(TMR_W)) u_pre_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (pre_i),
    .clear_i (clr_pre),
    .age_o   (pre_age)
  );

  spike_timer #(.W(TMR_W)) u_post_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (post_i),
    .clear_i (clr_post),
    .age_o   (post_age)
  );

  window_decider #(.TW(TMR_W)) u_dec (
    .pre_i      (pre_i),
    .post_i     (post_i),
    .pre_age_i  (pre_age),
    .post_age_i (post_age),
    .ltp_win_i  (ltp_win_i),
    .ltd_win_i  (ltd_win_i),
    .upd_o      (upd),
    .clr_pre_o  (clr_pre),
    .clr_post_o (clr_post)
  );

  eff_counter #(.W(EFF_W)) u_eff (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .upd_i      (upd),
    .eff_o      (eff_o),
    .inc_o      (ltp_o),
    .dec_o      (ltd_o)
  );

  // R5
  coincident_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && post_i) |=> !ltp_o && !ltd_o);

  // R3
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ltp_o && ltd_o));

  // R4
  ltp_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ltp_win_i == '0) |=> !ltp_o);
endmodule

// File: tb/stdp_rect_updater_tb.sv
module stdp_rect_updater_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pre = 1'b0, post = 1'b0, load = 1'b0;
  logic [15:0] ltp_win = 16'd5, ltd_win = 16'd4;
  logic [3:0]  load_val = 4'd0;
  logic [3:0]  eff;
  logic        ltp_f, ltd_f;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  stdp_rect_updater dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pre_i(pre), .post_i(post),
    .ltp_win_i(ltp_win), .ltd_win_i(ltd_win),
    .load_i(load), .load_val_i(load_val),
    .eff_o(eff), .ltp_o(ltp_f), .ltd_o(ltd_f)
  );

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic p, logic q);
    pre = p; post = q;
    @(negedge clk);
    pre = 1'b0; post = 1'b0;
  endtask

  task automatic restart(logic [3:0] v);
    rst_n = 1'b0; ltp_win = 16'd5; ltd_win = 16'd4;
    @(negedge clk);
    rst_n = 1'b1;
    load = 1'b1; load_val = v;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic ltp_pair(int gap);
    pulse(1, 0);
    idle(gap - 1);
    pulse(0, 1);
  endtask

  task automatic ltd_pair(int gap);
    pulse(0, 1);
    idle(gap - 1);
    pulse(1, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 eff", eff, 0);
    check("R1 ltp_o", ltp_f, 0);
    check("R1 ltd_o", ltd_f, 0);
    pulse(0, 1);
    check("R1 lone post ltp_o", ltp_f, 0);
    check("R1 lone post eff", eff, 0);
  endtask

  task automatic t_ltp();
    restart(7); ltp_pair(1);
    check("R2 gap1 eff", eff, 8);
    check("R2 gap1 ltp_o", ltp_f, 1);
    idle(1);
    check("R10 ltp_o drops", ltp_f, 0);
    check("R10 eff held", eff, 8);
    restart(7); ltp_pair(5);
    check("R2 gap=win eff", eff, 8);
    restart(7); ltp_pair(6);
    check("R4 ltp gap=win+1 eff", eff, 7);
    check("R4 ltp gap=win+1 flag", ltp_f, 0);
  endtask

  task automatic t_ltd();
    restart(7); ltd_pair(4);
    check("R3 gap=win eff", eff, 6);
    check("R3 gap=win ltd_o", ltd_f, 1);
    check("R3 no ltp_o", ltp_f, 0);
    restart(7); ltd_pair(1);
    check("R3 gap1 eff", eff, 6);
    restart(7); ltd_pair(5);
    check("R4 ltd gap=win+1 eff", eff, 7);
    check("R4 ltd gap=win+1 flag", ltd_f, 0);
  endtask

  task automatic t_zero_win();
    restart(7); ltp_win = 16'd0; ltp_pair(1);
    check("R4 ltp win0 eff", eff, 7);
    check("R4 ltp win0 flag", ltp_f, 0);
    restart(7); ltd_win = 16'd0; ltd_pair(1);
    check("R4 ltd win0 eff", eff, 7);
  endtask

  task automatic t_coincident();
    restart(7); pulse(1, 1);
    check("R5 eff", eff, 7);
    check("R5 ltp_o", ltp_f, 0);
    check("R5 ltd_o", ltd_f, 0);
  endtask

  task automatic t_saturate();
    restart(15); ltp_pair(1);
    check("R6 top eff", eff, 15);
    check("R6 top ltp_o", ltp_f, 1);
    restart(0); ltd_pair(1);
    check("R6 bottom eff", eff, 0);
    check("R6 bottom ltd_o", ltd_f, 1);
  endtask

  task automatic t_nearest();
    restart(7); ltp_pair(2);
    check("R7 first ltp eff", eff, 8);
    pulse(0, 1);
    check("R7 second post eff", eff, 8);
    check("R7 second post flag", ltp_f, 0);
    restart(7); ltd_pair(2);
    check("R7 first ltd eff", eff, 6);
    pulse(1, 0);
    check("R7 second pre eff", eff, 6);
    check("R7 second pre flag", ltd_f, 0);
  endtask

  task automatic t_load_prio();
    restart(7);
    pulse(1, 0);
    load = 1'b1; load_val = 4'd3;
    pulse(0, 1);
    load = 1'b0;
    check("R8 eff", eff, 3);
    check("R8 ltp_o", ltp_f, 0);
  endtask

  task automatic t_widen();
    restart(7); ltd_pair(6);
    check("R9 narrow eff", eff, 7);
    ltd_win = 16'd8;
    pulse(1, 0);
    check("R9 widened eff", eff, 6);
    check("R9 widened ltd_o", ltd_f, 1);
    restart(7); ltd_win = 16'd8; ltp_pair(6);
    check("R9 ltp window unchanged", eff, 7);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_ltp();
    t_ltd();
    t_zero_win();
    t_coincident();
    t_saturate();
    t_nearest();
    t_load_prio();
    t_widen();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule